// File: doc/BRIEF.md
# Per-Stream Ordering Issue Queue

This block sits inside a bridge, between the agents that produce transactions and one shared outbound link. Every pending transaction carries a 6-bit command code, a stream identifier and an isochronous flag. All transactions share one pool of entries, and the block chooses which one goes out next. Order is kept separately for each stream. Transactions of different streams may overtake each other freely. A fence command holds back everything queued behind it in its own stream. A flush command is held until every posted write already issued has been acknowledged as complete.

Arbitration takes place among the oldest entry of each stream that has one. Streams whose head entry is marked isochronous come first. Within a class, a round-robin pointer over stream numbers picks the winner, starting just after the stream that won last. The chosen entry moves into an output register and is offered on a valid/ready issue port. Posted writes raise a counter of outstanding writes when they are accepted, and the completion-acknowledge input lowers it.

Top module: `stream_order_queue`

## Requirements
- R1: `enqReady` is low while the pool holds DEPTH entries, which is 8 by default; the issue output register is not counted. An enqueue offered while `enqReady` is low is discarded and never issued.
- R2: Entries with the same stream number are issued in the order they were enqueued.
- R3: When arbitration takes place, a stream whose head entry has the isochronous flag set is served before any stream whose head entry does not have it.
- R4: Among eligible heads of the same class, the winner is the first stream with a request in ascending stream number after the previous winner, wrapping from NUM_STREAMS-1 to 0. After reset the previous winner is taken to be NUM_STREAMS-1.
- R5: A stream whose head is held back (a waiting flush) does not delay the issue of entries in other streams.
- R6: A fence (code 6'h3C) is forwarded on the issue port unchanged. No entry enqueued after it in the same stream is issued before it.
- R7: The outstanding-write count goes up by one when a posted write (code 6'h08) is accepted on the issue port, and down by one for each cycle with `cplAck` high. When both happen in the same cycle, the count does not change.
- R8: A flush (code 6'h02) is not presented on the issue port while the outstanding-write count is nonzero, or while a posted write is waiting in the issue register.
- R9: While `issValid` is high and `issReady` is low, `issValid`, `issType`, `issSid` and `issIso` hold their values.
- R10: After reset, `issValid` is low and `enqReady` is high. Other command codes, such as read 6'h10 and response 6'h30, follow only the ordering rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enqValid | input | 1 | Enqueue request |
| enqReady | output | 1 | Pool has a free entry |
| enqType | input | 6 | Command code of the entry being enqueued |
| enqSid | input | $clog2(NUM_STREAMS) | Stream number of the entry being enqueued |
| enqIso | input | 1 | Isochronous flag of the entry being enqueued |
| issValid | output | 1 | Issue register holds an entry |
| issReady | input | 1 | Link accepts the offered entry |
| issType | output | 6 | Command code being issued |
| issSid | output | $clog2(NUM_STREAMS) | Stream number being issued |
| issIso | output | 1 | Isochronous flag being issued |
| cplAck | input | 1 | One posted write has completed |

## Verification
Two events can meet in a single cycle: a posted write leaving on the issue port, and a completion acknowledge for an earlier write. To provoke this, the bench holds a second write in the issue register and then raises `issReady` and `cplAck` in the same cycle. It then queues a flush. If the design lets either event win over the other, the count ends up wrong, and the flush either leaves early or stays stuck after the last acknowledge. The scoreboard shows either fault as an unexpected item or as an item still waiting.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int CmdW = 6;

  localparam logic [CmdW-1:0] CMD_WRITE = 6'h08;
  localparam logic [CmdW-1:0] CMD_READ  = 6'h10;
  localparam logic [CmdW-1:0] CMD_RESP  = 6'h30;
  localparam logic [CmdW-1:0] CMD_FENCE = 6'h3C;
  localparam logic [CmdW-1:0] CMD_FLUSH = 6'h02;

  typedef struct packed {
    logic [CmdW-1:0] cmd;
    logic            iso;
  } entAttr_t;

  // control -> datapath strobes
  typedef struct packed {
    logic pop;   // move selected pool entry into the issue register
    logic take;  // issue register consumed by the link
  } ctlStrobe_t;
endpackage

// File: rtl/sq_data.sv
module sq_data
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SidW  = 5,
  localparam int IdxW = $clog2(DEPTH),
  localparam int CntW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enqValid,
  output logic            enqReady,
  input  logic [CmdW-1:0] enqType,
  input  logic [SidW-1:0] enqSid,
  input  logic            enqIso,
  input  ctlStrobe_t      strobe,
  input  logic [IdxW-1:0] popIdx,
  output logic            slotVld  [DEPTH],
  output logic [SidW-1:0] slotSid  [DEPTH],
  output entAttr_t        slotAttr [DEPTH],
  output logic            outVld,
  output logic [SidW-1:0] outSid,
  output entAttr_t        outAttr
);
  logic [CntW-1:0] count, nCnt;
  logic [SidW-1:0] nSid  [DEPTH];
  entAttr_t        nAttr [DEPTH];
  logic            enqAccept;

  assign enqReady  = (count != CntW'(DEPTH));
  assign enqAccept = enqValid && enqReady;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : gVld
      assign slotVld[g] = (CntW'(g) < count);
    end
  endgenerate

  // Pool is kept compacted in arrival order: removal shifts younger
  // entries down, an accepted enqueue lands at the new tail.
  always_comb begin
    nSid  = slotSid;
    nAttr = slotAttr;
    nCnt  = count;
    if (strobe.pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IdxW'(i) >= popIdx) begin
          nSid[i]  = slotSid[i+1];
          nAttr[i] = slotAttr[i+1];
        end
      end
      nCnt = count - 1'b1;
    end
    if (enqAccept) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CntW'(i) == nCnt) begin
          nSid[i]      = enqSid;
          nAttr[i].cmd = enqType;
          nAttr[i].iso = enqIso;
        end
      end
      nCnt = nCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        slotSid[i]  <= '0;
        slotAttr[i] <= '0;
      end
    end else begin
      count    <= nCnt;
      slotSid  <= nSid;
      slotAttr <= nAttr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outVld  <= 1'b0;
      outSid  <= '0;
      outAttr <= '0;
    end else if (strobe.pop) begin
      outVld  <= 1'b1;
      outSid  <= slotSid[popIdx];
      outAttr <= slotAttr[popIdx];
    end else if (strobe.take) begin
      outVld  <= 1'b0;
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rstN)
    count <= CntW'(DEPTH));

  p_full_drop_r1: assert property (@(posedge clk) disable iff (!rstN)
    (enqValid && !enqReady && !strobe.pop) |=> $stable(count));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outVld && !strobe.take) |=> (outVld && $stable(outSid) && $stable(outAttr)));
endmodule

// File: rtl/sq_ctrl.sv
module sq_ctrl
  import sq_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int NUM_STREAMS = 32,
  parameter int SidW        = 5,
  parameter int PendW       = 8,
  localparam int IdxW       = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            slotVld  [DEPTH],
  input  logic [SidW-1:0] slotSid  [DEPTH],
  input  entAttr_t        slotAttr [DEPTH],
  input  logic            outVld,
  input  entAttr_t        outAttr,
  input  logic            issReady,
  input  logic            cplAck,
  output ctlStrobe_t      strobe,
  output logic [IdxW-1:0] popIdx
);
  logic [DEPTH-1:0]       isHead, eligible;
  logic [NUM_STREAMS-1:0] reqIso, reqNrm, pickVec;
  logic [IdxW-1:0]        headIdx [NUM_STREAMS];
  logic [SidW-1:0]        rrPtr, win;
  logic                   found, flushOk;
  logic [PendW-1:0]       pendCnt;
  logic                   wrTake, ackDec;

  // A flush may leave only when no posted write is outstanding or waiting.
  assign flushOk = (pendCnt == '0) && !(outVld && outAttr.cmd == CMD_WRITE);

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : gHead
      always_comb begin
        isHead[g] = slotVld[g];
        for (int j = 0; j < g; j++) begin
          if (slotVld[j] && slotSid[j] == slotSid[g]) isHead[g] = 1'b0;
        end
      end
      assign eligible[g] = isHead[g] && !(slotAttr[g].cmd == CMD_FLUSH && !flushOk);
    end
  endgenerate

  always_comb begin
    reqIso = '0;
    reqNrm = '0;
    for (int s = 0; s < NUM_STREAMS; s++) headIdx[s] = '0;
    for (int s = 0; s < NUM_STREAMS; s++) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (eligible[i] && slotSid[i] == SidW'(s)) begin
          headIdx[s] = IdxW'(i);
          if (slotAttr[i].iso) reqIso[s] = 1'b1;
          else                 reqNrm[s] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    found   = 1'b0;
    win     = '0;
    pickVec = (|reqIso) ? reqIso : reqNrm;
    for (int k = 1; k <= NUM_STREAMS; k++) begin
      automatic int c = (int'(rrPtr) + k) % NUM_STREAMS;
      if (!found && pickVec[c]) begin
        found = 1'b1;
        win   = SidW'(c);
      end
    end
  end

  assign popIdx      = headIdx[win];
  assign strobe.take = outVld && issReady;
  assign strobe.pop  = found && (!outVld || issReady);

  assign wrTake = strobe.take && (outAttr.cmd == CMD_WRITE);
  assign ackDec = cplAck && (pendCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr   <= SidW'(NUM_STREAMS - 1);
      pendCnt <= '0;
    end else begin
      if (strobe.pop) rrPtr <= win;
      case ({wrTake, ackDec})
        2'b10:   pendCnt <= pendCnt + 1'b1;
        2'b01:   pendCnt <= pendCnt - 1'b1;
        default: pendCnt <= pendCnt;
      endcase
    end
  end

  p_flush_drained_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outVld && outAttr.cmd == CMD_FLUSH) |-> (pendCnt == '0));

  p_iso_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop && !slotAttr[popIdx].iso) |-> (reqIso == '0));

  p_pend_up_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && outAttr.cmd == CMD_WRITE && !cplAck) |=> (pendCnt == $past(pendCnt) + 1'b1));

  p_pend_both_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && outAttr.cmd == CMD_WRITE && cplAck && pendCnt != '0) |=> $stable(pendCnt));

  p_pend_no_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pendCnt == '1) |-> !(strobe.take && outAttr.cmd == CMD_WRITE && !cplAck));
endmodule

// File: rtl/stream_order_queue.sv
module stream_order_queue
  import sq_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int NUM_STREAMS = 32,
  parameter int PendW       = 8,
  localparam int SidW       = $clog2(NUM_STREAMS),
  localparam int IdxW       = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enqValid,
  output logic            enqReady,
  input  logic [5:0]      enqType,
  input  logic [SidW-1:0] enqSid,
  input  logic            enqIso,
  output logic            issValid,
  input  logic            issReady,
  output logic [5:0]      issType,
  output logic [SidW-1:0] issSid,
  output logic            issIso,
  input  logic            cplAck
);
  ctlStrobe_t      strobe;
  logic [IdxW-1:0] popIdx;
  logic            slotVld  [DEPTH];
  logic [SidW-1:0] slotSid  [DEPTH];
  entAttr_t        slotAttr [DEPTH];
  logic            outVld;
  logic [SidW-1:0] outSid;
  entAttr_t        outAttr;

  sq_data #(.DEPTH(DEPTH), .SidW(SidW)) uData (
    .clk(clk), .rstN(rstN),
    .enqValid(enqValid), .enqReady(enqReady),
    .enqType(enqType), .enqSid(enqSid), .enqIso(enqIso),
    .strobe(strobe), .popIdx(popIdx),
    .slotVld(slotVld), .slotSid(slotSid), .slotAttr(slotAttr),
    .outVld(outVld), .outSid(outSid), .outAttr(outAttr)
  );

  sq_ctrl #(.DEPTH(DEPTH), .NUM_STREAMS(NUM_STREAMS), .SidW(SidW), .PendW(PendW)) uCtrl (
    .clk(clk), .rstN(rstN),
    .slotVld(slotVld), .slotSid(slotSid), .slotAttr(slotAttr),
    .outVld(outVld), .outAttr(outAttr),
    .issReady(issReady), .cplAck(cplAck),
    .strobe(strobe), .popIdx(popIdx)
  );

  assign issValid = outVld;
  assign issType  = outAttr.cmd;
  assign issSid   = outSid;
  assign issIso   = outAttr.iso;
endmodule

// File: tb/stream_order_queue_test.sv
module stream_order_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] T_WR = 6'h08, T_RD = 6'h10, T_RS = 6'h30, T_FN = 6'h3C, T_FL = 6'h02;

  logic clk = 0, rstN = 0;
  logic enqValid = 0, enqIso = 0, issReady = 0, cplAck = 0;
  logic [5:0] enqType = '0;
  logic [4:0] enqSid = '0;
  logic enqReady, issValid, issIso;
  logic [5:0] issType;
  logic [4:0] issSid;

  typedef struct { logic [5:0] cmd; logic [4:0] sid; logic iso; string req; } exp_t;
  exp_t sbQ[$];
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  stream_order_queue uut (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqReady(enqReady),
    .enqType(enqType), .enqSid(enqSid), .enqIso(enqIso),
    .issValid(issValid), .issReady(issReady), .issType(issType),
    .issSid(issSid), .issIso(issIso), .cplAck(cplAck));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic expect_item(input logic [5:0] c, input logic [4:0] s, input logic i, input string r);
    exp_t e;
    e.cmd = c; e.sid = s; e.iso = i; e.req = r;
    sbQ.push_back(e);
  endtask

  // monitor: handshake seen at negedge completes at the next posedge
  always @(negedge clk) begin
    if (rstN && issValid && issReady) begin
      if (sbQ.size() == 0) begin
        check(0, "R2", "unexpected issue type/sid", {issType, 1'b0, issSid}, 0);
      end else begin
        exp_t e;
        e = sbQ.pop_front();
        check(issType == e.cmd && issSid == e.sid && issIso == e.iso, e.req,
              "issued item {type,sid,iso}", {issType, issSid, issIso}, {e.cmd, e.sid, e.iso});
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic enq(input logic [5:0] c, input logic [4:0] s, input logic i);
    enqValid = 1; enqType = c; enqSid = s; enqIso = i;
    forever begin
      @(negedge clk);
      if (enqReady) break;
    end
    @(posedge clk); #1;
    enqValid = 0;
  endtask

  task automatic drained(input string r);
    check(sbQ.size() == 0, r, "items still expected", sbQ.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1;
    @(negedge clk);
    check(issValid == 0, "R10", "issValid after reset", issValid, 0);
    check(enqReady == 1, "R10", "enqReady after reset", enqReady, 1);
    tick(1);

    // R3/R4/R2: iso first, round-robin, in-stream order
    enq(T_RD, 0, 0);          // blocker, rr -> 0
    enq(T_RD, 3, 0);
    enq(T_RD, 1, 0);
    enq(T_RS, 1, 0);
    enq(T_RD, 7, 1);
    enq(T_RS, 2, 1);
    tick(3);
    expect_item(T_RD, 0, 0, "R10");
    expect_item(T_RS, 2, 1, "R3");
    expect_item(T_RD, 7, 1, "R3");
    expect_item(T_RD, 1, 0, "R4");
    expect_item(T_RD, 3, 0, "R4");
    expect_item(T_RS, 1, 0, "R2");
    issReady = 1;
    tick(15);
    drained("R4");
    issReady = 0;

    // R6: fence forwarded, later same-stream entry waits behind it
    enq(T_RD, 0, 0);
    enq(T_FN, 4, 0);
    enq(T_RS, 4, 0);
    enq(T_RD, 6, 0);
    tick(3);
    expect_item(T_RD, 0, 0, "R6");
    expect_item(T_FN, 4, 0, "R6");
    expect_item(T_RD, 6, 0, "R4");
    expect_item(T_RS, 4, 0, "R6");
    issReady = 1;
    tick(15);
    drained("R6");

    // R8/R5: flush waits for completion, other stream passes
    expect_item(T_WR, 9, 0, "R7");
    expect_item(T_RD, 10, 0, "R5");
    enq(T_WR, 9, 0);
    tick(4);
    enq(T_FL, 9, 0);
    enq(T_RD, 10, 0);
    tick(15);
    drained("R5");
    @(negedge clk);
    check(issValid == 0, "R8", "flush held while write outstanding", issValid, 0);
    tick(1);
    expect_item(T_FL, 9, 0, "R8");
    cplAck = 1; tick(1); cplAck = 0;
    tick(8);
    drained("R8");

    // R7: write accept and completion in the same cycle
    issReady = 0;
    enq(T_WR, 11, 0);
    tick(3);
    expect_item(T_WR, 11, 0, "R7");
    issReady = 1; tick(1); issReady = 0;      // count 1
    expect_item(T_WR, 11, 0, "R7");
    enq(T_WR, 11, 0);
    tick(3);
    issReady = 1; cplAck = 1; tick(1); cplAck = 0;   // count stays 1
    enq(T_FL, 11, 0);
    tick(12);
    drained("R7");
    @(negedge clk);
    check(issValid == 0, "R7", "flush held after simultaneous accept and ack", issValid, 0);
    tick(1);
    expect_item(T_FL, 11, 0, "R7");
    cplAck = 1; tick(1); cplAck = 0;
    tick(8);
    drained("R7");

    // R1/R9: fill the pool, refused enqueue, output held
    issReady = 0;
    for (int k = 0; k < 9; k++) begin
      enq((k % 3 == 0) ? T_RD : (k % 3 == 1) ? T_RS : T_FN, 12, 0);
    end
    @(negedge clk);
    check(enqReady == 0, "R1", "enqReady with pool full", enqReady, 0);
    tick(1);
    enqValid = 1; enqType = T_RD; enqSid = 12; enqIso = 0;
    tick(4);
    enqValid = 0;
    @(negedge clk);
    check(enqReady == 0, "R1", "enqReady still low", enqReady, 0);
    check(issValid == 1 && issType == T_RD && issSid == 12, "R9", "held issue type",
          issType, T_RD);
    tick(3);
    @(negedge clk);
    check(issValid == 1 && issType == T_RD && issSid == 12, "R9", "issue type after stall",
          issType, T_RD);
    tick(1);
    for (int k = 0; k < 9; k++) begin
      expect_item((k % 3 == 0) ? T_RD : (k % 3 == 1) ? T_RS : T_FN, 12, 0, "R2");
    end
    issReady = 1;
    tick(25);
    drained("R1");
    @(negedge clk);
    check(issValid == 0, "R1", "refused entry never issued", issValid, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule